// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block holds the software-visible programming state of a four-channel DMA controller in the classic PC style. A host reaches it through an 8-bit data port, a 4-bit register offset, and separate write and read strobes. Each channel has a 16-bit address and a 16-bit count. Both are kept as a base copy and as a current copy. The block also holds a command byte, one mode byte per channel, a request bit and a mask bit per channel, and a status byte. Every port is one byte wide, so the host reaches each 16-bit channel register through a single offset. A shared byte-pointer flip-flop decides whether an access hits the low byte or the high byte.

A transfer engine sits beside the block. It reads the mode, mask, request, command and programmed values from dedicated outputs. It writes back the current address and count of one channel at a time, and it can flag that channel's terminal count. The status byte gathers the terminal-count flags and the pending requests for the host to read. The engine encodes the number of transfers as the count minus one, so 0x0000 means one transfer and 0xFFFF means 65536 transfers. This register file stores that value as written.

Top module: `dma_regfile`

## Requirements
- R1: An access (read or write) to any offset 0x0 to 0x7 hits the low byte of the selected register when the byte pointer is 0 and the high byte when it is 1. The pointer then toggles.
- R2: Any write to offset 0xC clears the byte pointer, so the next channel access hits the low byte.
- R3: Offset 2n selects channel n's address and offset 2n+1 selects its count, for n = 0 to 3. A write loads the addressed byte into both the base and the current register. A read returns the current register.
- R4: An engine update (`eng_upd_i`) loads `eng_addr_i` and `eng_cnt_i` into the current registers of channel `eng_ch_i` and leaves the base registers unchanged. If a host write hits the same register in the same cycle, the host write wins for that register only.
- R5: A write to 0xA sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel given by data bits [1:0]. Other masks are unchanged.
- R6: A write to 0xB stores data bits [7:2] as the mode of the channel given by data bits [1:0], and `mode_o` slice n carries it. Examples: 0x44 gives I/O-to-memory, 0x48 gives memory-to-I/O, bit 4 enables autoinitialize, and bits [7:6] = 11 select cascade.
- R7: A write to 0xD is a master clear. It sets all four masks and clears the command, the request bits, the terminal-count flags and the byte pointer. A read of 0xD returns 0x00.
- R8: A write to 0xE clears all masks. A write to 0xF loads mask n from data bit n.
- R9: A write to 0x8 loads the command byte onto `cmd_o`. A write to 0x9 sets (bit 2 = 1) or clears (bit 2 = 0) the request bit of the channel given by data bits [1:0].
- R10: A read of 0x8 returns status. Bits [3:0] are the terminal-count flags, which an engine update with `eng_tc_i` sets. Bits [7:4] are the request bits ORed with `drq_i`. A status read clears the terminal-count flags after it returns them, but a flag set in the same cycle survives.
- R11: After reset all masks are set, and every other register and the byte pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational from offset) |
| eng_upd_i | input | 1 | Engine update of current address and count |
| eng_ch_i | input | 2 | Channel the engine updates |
| eng_addr_i | input | 16 | New current address |
| eng_cnt_i | input | 16 | New current count |
| eng_tc_i | input | 1 | Terminal count reached on `eng_ch_i` |
| drq_i | input | 4 | Hardware requests, one per channel |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 24 | Per-channel mode bits [7:2], six bits per channel |
| mask_o | output | 4 | Channel masks |
| req_o | output | 4 | Software request bits |
| base_addr_o | output | 64 | Base address, 16 bits per channel |
| base_cnt_o | output | 64 | Base count, 16 bits per channel |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| cur_cnt_o | output | 64 | Current count, 16 bits per channel |

## Verification
The assertions check on every cycle that the byte pointer clears and toggles as required. They also check that a host byte lands in both the base and current copies, and that an engine update leaves the base registers alone. Further assertions cover the master clear, the single-mask write changing at most one mask, and a status read emptying the terminal-count flags. Only the bench's scenarios show the complete picture. They read back whole 16-bit values through the byte pointer and resolve the same-cycle collision between the host and the engine. They also decode each mode value per channel and assemble the status byte from request bits and `drq_i`.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam int N_CH   = 4;
  localparam int CH_W   = $clog2(N_CH);
  localparam int DW     = 8;
  localparam int AW     = 2 * DW;
  localparam int OFS_W  = 4;
  localparam int MODE_W = DW - CH_W;

  localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [OFS_W-1:0] OFS_PTRCLR  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [OFS_W-1:0] OFS_UNMASK  = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          hi_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eng_ld_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [AW-1:0] eng_cnt_i,
  output logic [AW-1:0] base_addr_o,
  output logic [AW-1:0] base_cnt_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] cur_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_o <= '0;
      cur_addr_o  <= '0;
    end else if (wr_addr_i) begin
      if (hi_sel_i) begin
        base_addr_o[AW-1:DW] <= wdata_i;
        cur_addr_o[AW-1:DW]  <= wdata_i;
      end else begin
        base_addr_o[DW-1:0] <= wdata_i;
        cur_addr_o[DW-1:0]  <= wdata_i;
      end
    end else if (eng_ld_i) begin
      cur_addr_o <= eng_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt_o <= '0;
      cur_cnt_o  <= '0;
    end else if (wr_cnt_i) begin
      if (hi_sel_i) begin
        base_cnt_o[AW-1:DW] <= wdata_i;
        cur_cnt_o[AW-1:DW]  <= wdata_i;
      end else begin
        base_cnt_o[DW-1:0] <= wdata_i;
        cur_cnt_o[DW-1:0]  <= wdata_i;
      end
    end else if (eng_ld_i) begin
      cur_cnt_o <= eng_cnt_i;
    end
  end

  assert_host_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i && !hi_sel_i) |=> (cur_addr_o[DW-1:0] == $past(wdata_i)) &&
                                 (base_addr_o[DW-1:0] == $past(wdata_i)));

  assert_eng_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_ld_i && !wr_cnt_i) |=> (cur_cnt_o == $past(eng_cnt_i)) && $stable(base_cnt_o));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regfile_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [OFS_W-1:0]       addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [N_CH-1:0]        tc_set_i,
  input  logic [N_CH-1:0]        drq_i,
  output logic                   hi_sel_o,
  output logic [DW-1:0]          cmd_o,
  output logic [N_CH*MODE_W-1:0] mode_o,
  output logic [N_CH-1:0]        mask_o,
  output logic [N_CH-1:0]        req_o,
  output logic [DW-1:0]          status_o
);
  logic [MODE_W-1:0] mode_q [N_CH];
  logic [N_CH-1:0]   tc_q;
  logic [CH_W-1:0]   sel_ch;
  logic              chan_acc, ptr_clr, stat_rd;

  assign sel_ch   = wdata_i[CH_W-1:0];
  assign chan_acc = (wr_i || rd_i) && !addr_i[OFS_W-1];
  assign ptr_clr  = wr_i && (addr_i == OFS_PTRCLR || addr_i == OFS_MCLR);
  assign stat_rd  = rd_i && addr_i == OFS_CMD;
  assign status_o = {req_o | drq_i, tc_q};

  for (genvar c = 0; c < N_CH; c++) begin : g_mode
    assign mode_o[c*MODE_W +: MODE_W] = mode_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_sel_o <= 1'b0;
      cmd_o    <= '0;
      mask_o   <= '1;
      req_o    <= '0;
      tc_q     <= '0;
      for (int c = 0; c < N_CH; c++) mode_q[c] <= '0;
    end else begin
      if (ptr_clr)       hi_sel_o <= 1'b0;
      else if (chan_acc) hi_sel_o <= ~hi_sel_o;
      // set beats a concurrent status-read clear
      tc_q <= (stat_rd ? '0 : tc_q) | tc_set_i;
      if (wr_i) begin
        case (addr_i)
          OFS_CMD:     cmd_o <= wdata_i;
          OFS_REQ:     req_o[sel_ch] <= wdata_i[2];
          OFS_MASK1:   mask_o[sel_ch] <= wdata_i[2];
          OFS_MODE:    mode_q[sel_ch] <= wdata_i[DW-1:CH_W];
          OFS_MCLR: begin
            cmd_o  <= '0;
            req_o  <= '0;
            mask_o <= '1;
            tc_q   <= '0;
          end
          OFS_UNMASK:  mask_o <= '0;
          OFS_MASKALL: mask_o <= wdata_i[N_CH-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_ptr_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_acc |=> hi_sel_o != $past(hi_sel_o));

  assert_ptr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_PTRCLR) |=> !hi_sel_o);

  assert_single_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_MASK1) |=> $countones(mask_o ^ $past(mask_o)) <= 1);

  assert_master_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_MCLR) |=> (mask_o == '1) && (cmd_o == '0) && (req_o == '0) && !hi_sel_o);

  assert_tc_read_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && tc_set_i == '0 && !wr_i) |=> status_o[N_CH-1:0] == '0);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [OFS_W-1:0]       addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic                   eng_upd_i,
  input  logic [CH_W-1:0]        eng_ch_i,
  input  logic [AW-1:0]          eng_addr_i,
  input  logic [AW-1:0]          eng_cnt_i,
  input  logic                   eng_tc_i,
  input  logic [N_CH-1:0]        drq_i,
  output logic [DW-1:0]          cmd_o,
  output logic [N_CH*MODE_W-1:0] mode_o,
  output logic [N_CH-1:0]        mask_o,
  output logic [N_CH-1:0]        req_o,
  output logic [N_CH*AW-1:0]     base_addr_o,
  output logic [N_CH*AW-1:0]     base_cnt_o,
  output logic [N_CH*AW-1:0]     cur_addr_o,
  output logic [N_CH*AW-1:0]     cur_cnt_o
);
  logic            hi_sel;
  logic [DW-1:0]   status;
  logic [N_CH-1:0] tc_set;
  logic [AW-1:0]   cur_addr_w [N_CH];
  logic [AW-1:0]   cur_cnt_w  [N_CH];

  assign tc_set = (eng_upd_i && eng_tc_i) ? (N_CH'(1) << eng_ch_i) : '0;

  dma_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .tc_set_i (tc_set),
    .drq_i,
    .hi_sel_o (hi_sel),
    .cmd_o, .mode_o, .mask_o, .req_o,
    .status_o (status)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_chan_regs u_chan (
      .clk_i, .rst_ni,
      .wr_addr_i   (wr_i && addr_i == OFS_W'(2*c)),
      .wr_cnt_i    (wr_i && addr_i == OFS_W'(2*c+1)),
      .hi_sel_i    (hi_sel),
      .wdata_i,
      .eng_ld_i    (eng_upd_i && eng_ch_i == CH_W'(c)),
      .eng_addr_i,
      .eng_cnt_i,
      .base_addr_o (base_addr_o[c*AW +: AW]),
      .base_cnt_o  (base_cnt_o[c*AW +: AW]),
      .cur_addr_o  (cur_addr_w[c]),
      .cur_cnt_o   (cur_cnt_w[c])
    );
    assign cur_addr_o[c*AW +: AW] = cur_addr_w[c];
    assign cur_cnt_o[c*AW +: AW]  = cur_cnt_w[c];
  end

  logic [AW-1:0] rd_word;
  always_comb begin
    rd_word = addr_i[0] ? cur_cnt_w[addr_i[CH_W:1]] : cur_addr_w[addr_i[CH_W:1]];
    if (!addr_i[OFS_W-1])     rdata_o = hi_sel ? rd_word[AW-1:DW] : rd_word[DW-1:0];
    else if (addr_i == OFS_CMD) rdata_o = status;
    else                        rdata_o = '0;
  end
endmodule

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 0, rd = 0, eng_upd = 0, eng_tc = 0;
  logic [3:0]  addr = 0, drq = 0;
  logic [7:0]  wdata = 0, rdata, cmd;
  logic [1:0]  eng_ch = 0;
  logic [15:0] eng_addr = 0, eng_cnt = 0;
  logic [23:0] mode;
  logic [3:0]  mask, req;
  logic [63:0] base_addr, base_cnt, cur_addr, cur_cnt;
  int total = 0, fails = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  dma_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .eng_upd_i(eng_upd), .eng_ch_i(eng_ch),
    .eng_addr_i(eng_addr), .eng_cnt_i(eng_cnt), .eng_tc_i(eng_tc), .drq_i(drq),
    .cmd_o(cmd), .mode_o(mode), .mask_o(mask), .req_o(req),
    .base_addr_o(base_addr), .base_cnt_o(base_cnt),
    .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic eng(logic [1:0] c, logic [15:0] a, logic [15:0] n, logic t);
    @(negedge clk); eng_ch = c; eng_addr = a; eng_cnt = n; eng_tc = t; eng_upd = 1;
    @(negedge clk); eng_upd = 0; eng_tc = 0;
  endtask

  task automatic t_reset;
    check("R11 mask", mask, 4'hF);
    check("R11 cmd", cmd, 0);
    check("R11 base", base_addr, 0);
    rd_reg(4'h8, d); check("R11 status", d, 0);
  endtask

  task automatic t_chan;
    wr_reg(4'hC, 0);
    wr_reg(4'h4, 8'h34); wr_reg(4'h4, 8'h12);
    wr_reg(4'h5, 8'hFF); wr_reg(4'h5, 8'h00);
    check("R3 base addr ch2", base_addr[32 +: 16], 16'h1234);
    check("R3 cur addr ch2", cur_addr[32 +: 16], 16'h1234);
    check("R3 base cnt ch2", base_cnt[32 +: 16], 16'h00FF);
    rd_reg(4'h4, d); check("R1 read low", d, 8'h34);
    rd_reg(4'h4, d); check("R1 read high", d, 8'h12);
    rd_reg(4'h5, d); check("R3 cnt low", d, 8'hFF);
    rd_reg(4'h5, d); check("R3 cnt high", d, 8'h00);
  endtask

  task automatic t_ptr_clear;
    wr_reg(4'hC, 0);
    wr_reg(4'h0, 8'hAA);
    wr_reg(4'hC, 0);
    wr_reg(4'h0, 8'hBB);
    check("R2 low byte again", base_addr[0 +: 16], 16'h00BB);
    wr_reg(4'hC, 0);
  endtask

  task automatic t_engine;
    eng(2'd2, 16'h2000, 16'h0010, 1'b1);
    check("R4 cur addr", cur_addr[32 +: 16], 16'h2000);
    check("R4 cur cnt", cur_cnt[32 +: 16], 16'h0010);
    check("R4 base kept", base_addr[32 +: 16], 16'h1234);
    rd_reg(4'h8, d); check("R10 tc flag", d, 8'h04);
    rd_reg(4'h8, d); check("R10 tc cleared", d, 8'h00);
    // host write and engine update on channel 1 in one cycle
    wr_reg(4'hC, 0);
    @(negedge clk);
    addr = 4'h2; wdata = 8'h55; wr = 1;
    eng_ch = 2'd1; eng_addr = 16'h9999; eng_cnt = 16'h7777; eng_upd = 1;
    @(negedge clk); wr = 0; eng_upd = 0;
    check("R4 host wins addr", cur_addr[16 +: 16], 16'h0055);
    check("R4 engine cnt", cur_cnt[16 +: 16], 16'h7777);
    wr_reg(4'hC, 0);
  endtask

  task automatic t_mask;
    wr_reg(4'hE, 0);    check("R8 unmask all", mask, 4'h0);
    wr_reg(4'hA, 8'h06); check("R5 set ch2", mask, 4'b0100);
    wr_reg(4'hA, 8'h02); check("R5 clear ch2", mask, 4'b0000);
    wr_reg(4'hF, 8'h0A); check("R8 load all", mask, 4'b1010);
  endtask

  task automatic t_mode;
    wr_reg(4'hB, 8'h46);
    wr_reg(4'hB, 8'hC3);
    wr_reg(4'hB, 8'h59);
    check("R6 ch2 io-to-mem", mode[12 +: 6], 6'h11);
    check("R6 ch3 cascade", mode[18 +: 6], 6'h30);
    check("R6 ch1 autoinit", mode[6 +: 6], 6'h16);
    check("R6 ch0 untouched", mode[0 +: 6], 6'h00);
  endtask

  task automatic t_cmd_req;
    wr_reg(4'h8, 8'h5A); check("R9 cmd", cmd, 8'h5A);
    wr_reg(4'h9, 8'h05); check("R9 req set", req, 4'b0010);
    drq = 4'b1000;
    rd_reg(4'h8, d); check("R10 status high", d, 8'hA0);
    drq = 4'b0000;
    wr_reg(4'h9, 8'h01); check("R9 req clear", req, 4'b0000);
  endtask

  task automatic t_master;
    wr_reg(4'h9, 8'h06);
    eng(2'd0, 16'h0000, 16'h0000, 1'b1);
    wr_reg(4'h0, 8'h11);
    wr_reg(4'hD, 0);
    check("R7 masks", mask, 4'hF);
    check("R7 cmd", cmd, 0);
    check("R7 req", req, 0);
    rd_reg(4'h8, d); check("R7 status", d, 8'h00);
    rd_reg(4'hD, d); check("R7 temp read", d, 8'h00);
    wr_reg(4'h0, 8'h77);
    check("R7 pointer cleared", base_addr[0 +: 16], 16'h0077);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_chan;
    t_ptr_clear;
    t_engine;
    t_mask;
    t_mode;
    t_cmd_req;
    t_master;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule